// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a SPI master that performs exactly one serial-flash transaction each time software sets a start bit. Software programs three 32-bit registers: a command word (command byte plus a 24-bit flash address), a payload word that holds up to four data bytes, and a control word. The control word packs a transmit byte count, a receive byte count and the start bit. Software polls a busy flag in the control word before touching the registers and before reading back results.

Once started, the engine lowers chip select and sends the transmit bytes. The command word supplies the first four bytes and the payload word supplies any bytes after that. The engine then clocks in the requested number of receive bytes, which land zero-extended in the payload register. The serial interface runs in SPI mode 0. One serial clock period takes two system clock cycles, so each byte occupies sixteen cycles and consecutive bytes follow with no gap.

Top module: `spi_cmd_engine`

## Requirements
- R1: Register 0 (control) reads back the transmit count in bits 3:0, the receive count in bits 7:4, zero in bit 8, and busy in bit 16. Writing it with bit 8 clear only stores the counts and starts nothing.
- R2: The command word sends its bits 7:0 first, then its bits 31:24, 23:16 and 15:8. Transmit counts of 1 to 4 send that many of these bytes in this order.
- R3: With a transmit count of 5 to 8, the bytes after the first four come from the payload register, least significant byte first. A transmit count above 8 acts as 8.
- R4: Receive byte k (from 0) is stored in payload bits 8k+7:8k, and the unreceived upper bytes read as zero. A receive count above 4 acts as 4. A transaction with a receive count of 0 leaves the payload register unchanged.
- R5: Chip select (active low) stays low for exactly 16 cycles per byte. The serial clock idles low and alternates one cycle low, one cycle high for each bit. During receive bytes MOSI is 0.
- R6: Busy reads 1 starting in the cycle after the edge that accepts the start write. Chip select rises 16·N cycles after that edge, and busy falls one cycle later.
- R7: While busy, writes to any register, including a new start, are ignored.
- R8: A start whose effective transmit plus receive count is zero is ignored: busy stays 0 and chip select stays high.
- R9: Bits go out most significant bit first on MOSI, stable while the clock is high. MISO is sampled as the clock rises, most significant bit first.
- R10: After reset, chip select is high, the serial clock and MOSI are low, and all three registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 command, 2 payload |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register selected by addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest case to reach is a register write that arrives in the middle of a running transaction. To produce it, the bench issues a short one-byte command and follows it at once with a second start that has larger counts, then with command and payload writes. It then checks that the chip-select window still matches the first command and that all three registers still hold their earlier values. The saturation cases (counts of 15) and the zero-count start are also driven directly, and the reference model compares every cycle against the expected serial waveform.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int REG_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 4;
    localparam int ADDR_W    = 2;
    localparam int MAX_TX    = 8;
    localparam int MAX_RX    = 4;
    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;
    localparam int BIT_W     = $clog2(BYTE_W);

    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CMD  = 2'd1;
    localparam logic [ADDR_W-1:0] REG_PAY  = 2'd2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SHIFT,
        SEQ_GAP
    } seq_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done
);
    typedef struct packed {
        logic              run;
        logic              phase;
        logic [BIT_W-1:0]  bitn;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d         = q;
        byte_done = q.run && q.phase && (q.bitn == BIT_W'(BYTE_W - 1));
        if (q.run) begin
            if (!q.phase) begin
                d.phase = 1'b1;
                d.rx    = {q.rx[BYTE_W-2:0], miso};
            end else begin
                d.phase = 1'b0;
                d.bitn  = q.bitn + 1'b1;
                d.sh    = {q.sh[BYTE_W-2:0], 1'b0};
                if (byte_done) d.run = 1'b0;
            end
        end
        if (load) begin
            d.run   = 1'b1;
            d.phase = 1'b0;
            d.bitn  = '0;
            d.sh    = tx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.run & q.phase;
    assign mosi    = q.run & q.sh[BYTE_W-1];
    assign rx_byte = q.rx;

    // R5
    load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !sclk);
    // R9
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !load) |=> $stable(mosi) || !sclk);
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [REG_W-1:0]  cmd_word,
    input  logic [REG_W-1:0]  pay_word,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              busy,
    output logic              cs_n,
    output logic              rx_load,
    output logic [REG_W-1:0]  rx_word
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] txn;
        logic [CNT_W-1:0] tot;
        logic [CNT_W-1:0] idx;
        logic [REG_W-1:0] acc;
    } seq_t;

    seq_t q, d;
    logic [CNT_W-1:0] tx_eff, rx_eff, total, next_idx, sel_txn, rx_k;

    function automatic logic [BYTE_W-1:0] pick(input logic [CNT_W-1:0] i,
                                               input logic [CNT_W-1:0] lim,
                                               input logic [REG_W-1:0] cmd,
                                               input logic [REG_W-1:0] pay);
        if (i >= lim) return '0;
        case (i)
            4'd0:    return cmd[7:0];
            4'd1:    return cmd[31:24];
            4'd2:    return cmd[23:16];
            4'd3:    return cmd[15:8];
            default: return BYTE_W'(pay >> {i[1:0], 3'b000});
        endcase
    endfunction

    always_comb begin
        tx_eff   = (tx_cnt > CNT_W'(MAX_TX)) ? CNT_W'(MAX_TX) : tx_cnt;
        rx_eff   = (rx_cnt > CNT_W'(MAX_RX)) ? CNT_W'(MAX_RX) : rx_cnt;
        total    = tx_eff + rx_eff;
        rx_k     = q.idx - q.txn;
        d        = q;
        load     = 1'b0;
        rx_load  = 1'b0;
        next_idx = '0;
        case (q.state)
            SEQ_IDLE: begin
                if (start_req && total != '0) begin
                    d.state = SEQ_SHIFT;
                    d.txn   = tx_eff;
                    d.tot   = total;
                    d.idx   = '0;
                    d.acc   = '0;
                    load    = 1'b1;
                end
            end
            SEQ_SHIFT: begin
                if (byte_done) begin
                    if (q.idx >= q.txn)
                        d.acc = q.acc | (REG_W'(rx_byte) << {rx_k[1:0], 3'b000});
                    if (q.idx == q.tot - 1'b1) begin
                        d.state = SEQ_GAP;
                        rx_load = (q.tot != q.txn);
                    end else begin
                        d.idx    = q.idx + 1'b1;
                        next_idx = q.idx + 1'b1;
                        load     = 1'b1;
                    end
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
        sel_txn = (q.state == SEQ_IDLE) ? tx_eff : q.txn;
        tx_byte = pick(next_idx, sel_txn, cmd_word, pay_word);
        rx_word = d.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: SEQ_IDLE, default: '0};
        else        q <= d;
    end

    assign busy = (q.state != SEQ_IDLE);
    assign cs_n = (q.state != SEQ_SHIFT);

    // R6
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> !busy);
    // R8
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && tx_cnt == '0 && rx_cnt == '0) |=> !busy);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    typedef struct packed {
        logic [2*CNT_W-1:0] cnt;
        logic [REG_W-1:0]   cmd;
        logic [REG_W-1:0]   pay;
    } regs_t;

    regs_t q, d;
    logic busy, start_req, load, byte_done, rx_load;
    logic [BYTE_W-1:0] tx_byte, rx_byte;
    logic [REG_W-1:0]  rx_word;

    assign start_req = wr_en && !busy && addr == REG_CTRL && wdata[START_BIT];

    always_comb begin
        d = q;
        if (wr_en && !busy) begin
            case (addr)
                REG_CTRL: d.cnt = wdata[2*CNT_W-1:0];
                REG_CMD:  d.cmd = wdata;
                REG_PAY:  d.pay = wdata;
                default:  ;
            endcase
        end
        if (rx_load) d.pay = rx_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: begin
                rdata[2*CNT_W-1:0] = q.cnt;
                rdata[BUSY_BIT]    = busy;
            end
            REG_CMD: rdata = q.cmd;
            REG_PAY: rdata = q.pay;
            default: rdata = '0;
        endcase
    end

    spi_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .tx_cnt    (wdata[CNT_W-1:0]),
        .rx_cnt    (wdata[2*CNT_W-1:CNT_W]),
        .cmd_word  (q.cmd),
        .pay_word  (q.pay),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .load      (load),
        .tx_byte   (tx_byte),
        .busy      (busy),
        .cs_n      (spi_cs_n),
        .rx_load   (rx_load),
        .rx_word   (rx_word)
    );

    spi_byte_shifter u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tx_byte   (tx_byte),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && addr == REG_CTRL && wdata[START_BIT]));
    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.cmd));
    // R5
    sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);
endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, miso = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cs_n, sclk, mosi;

    spi_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // flash-side responder: byte i of a transaction is resp[i]
    logic [7:0] resp [12];
    int s_bit = 0;
    always @(negedge cs_n) begin
        s_bit = 0;
        miso  = resp[0][7];
    end
    always @(negedge sclk) begin
        s_bit++;
        if (s_bit < 96) miso = resp[s_bit/8][7 - s_bit%8];
    end

    // behavioural reference model
    logic [31:0] m_cmd = '0, m_pay = '0;
    logic [7:0]  m_cnt = '0;
    logic [7:0]  m_bytes [12];
    int m_k = -1, m_n = 0, m_txe = 0, m_rxe = 0;

    always @(posedge clk) begin
        bit was_idle;
        if (!rst_n) begin
            m_k = -1; m_cmd = '0; m_pay = '0; m_cnt = '0;
        end else begin
            was_idle = (m_k < 0);
            if (m_k >= 0) begin
                if (m_k == 16*m_n) m_k = -1;
                else begin
                    m_k++;
                    if (m_k == 16*m_n && m_rxe > 0) begin
                        m_pay = '0;
                        for (int j = 0; j < m_rxe; j++) m_pay[8*j +: 8] = resp[m_txe + j];
                    end
                end
            end
            if (was_idle && wr_en) begin
                case (addr)
                    2'd0: begin
                        m_cnt = wdata[7:0];
                        if (wdata[8]) begin
                            m_txe = (wdata[3:0] > 8) ? 8 : int'(wdata[3:0]);
                            m_rxe = (wdata[7:4] > 4) ? 4 : int'(wdata[7:4]);
                            if (m_txe + m_rxe > 0) begin
                                m_n = m_txe + m_rxe;
                                for (int i = 0; i < 12; i++) begin
                                    if (i >= m_txe)  m_bytes[i] = 8'h00;
                                    else if (i == 0) m_bytes[i] = m_cmd[7:0];
                                    else if (i < 4)  m_bytes[i] = m_cmd[8*(4-i) +: 8];
                                    else             m_bytes[i] = m_pay[8*(i-4) +: 8];
                                end
                                m_k = 0;
                            end
                        end
                    end
                    2'd1: m_cmd = wdata;
                    2'd2: m_pay = wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison of the serial pins and the busy flag
    always @(negedge clk) begin
        logic act;
        logic e_cs, e_sclk, e_mosi;
        if (rst_n) begin
            #1;
            act    = (m_k >= 0 && m_k < 16*m_n);
            e_cs   = !act;
            e_sclk = act && (m_k % 2 == 1);
            e_mosi = act ? m_bytes[m_k/16][7 - (m_k/2)%8] : 1'b0;
            check("R5", "cs_n", 32'(cs_n), 32'(e_cs));
            check("R5", "sclk", 32'(sclk), 32'(e_sclk));
            check("R9", "mosi", 32'(mosi), 32'(e_mosi));
            if (addr == 2'd0) check("R6", "busy", 32'(rdata[16]), 32'(m_k >= 0));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] dv);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = dv;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp,
                      input string req, input string what);
        @(negedge clk);
        addr = a;
        #2;
        check(req, what, rdata, exp);
        addr = 2'd0;
    endtask

    task automatic wait_idle();
        while (m_k >= 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input int tx, input int rx,
                       input logic [31:0] c, input logic [31:0] p);
        wr(2'd1, c);
        wr(2'd2, p);
        wr(2'd0, {23'd0, 1'b1, 4'(rx), 4'(tx)});
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) resp[i] = 8'(8'h5A + i*17);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "cs_n", 32'(cs_n), 32'd1);
        check("R10", "sclk", 32'(sclk), 32'd0);
        check("R10", "mosi", 32'(mosi), 32'd0);
        check("R10", "ctrl", rdata, 32'd0);
        rst_n = 1'b1;
        rd(2'd1, 32'd0, "R10", "cmd reg");
        rd(2'd2, 32'd0, "R10", "payload reg");

        // R1 count readback without start
        wr(2'd0, 32'h0000_00A3);
        repeat (3) @(negedge clk);
        rd(2'd0, 32'h0000_00A3, "R1", "ctrl readback");

        // R2 one-byte command, payload untouched (R4)
        run(1, 0, 32'h0000_0006, 32'hCAFE_F00D);
        rd(2'd2, 32'hCAFE_F00D, "R4", "payload kept rx0");

        // R4 one-byte status read
        run(1, 1, 32'h0000_0005, 32'h1111_1111);
        rd(2'd2, {24'd0, resp[1]}, "R4", "status byte");

        // R2 address order, one receive byte
        run(4, 1, 32'h1234_56AB, 32'h0);
        rd(2'd2, {24'd0, resp[4]}, "R4", "signature byte");

        // R3 eight-byte program
        run(8, 0, 32'hA5B6_C702, 32'h4433_2211);
        rd(2'd2, 32'h4433_2211, "R3", "payload after program");

        // R3 partial payload plus two receive bytes
        run(6, 2, 32'h0102_0399, 32'h8877_6655);
        rd(2'd2, {16'd0, resp[7], resp[6]}, "R4", "two rx bytes");

        // R4 full four-byte receive
        run(2, 4, 32'h0000_7E3B, 32'h0);
        rd(2'd2, {resp[5], resp[4], resp[3], resp[2]}, "R4", "four rx bytes");

        // R3 R4 saturating counts
        run(15, 15, 32'hDEAD_BEEF, 32'hFEED_C0DE);
        rd(2'd2, {resp[11], resp[10], resp[9], resp[8]}, "R4", "saturated rx");

        // R8 zero-count start
        wr(2'd0, 32'h0000_0100);
        repeat (3) @(negedge clk);
        rd(2'd0, 32'h0000_0000, "R8", "ctrl after empty start");
        check("R8", "cs_n", 32'(cs_n), 32'd1);

        // R7 writes during a running transaction
        wr(2'd1, 32'h0000_0004);
        wr(2'd2, 32'h5555_AAAA);
        wr(2'd0, 32'h0000_0101);
        wr(2'd0, 32'h0000_0148);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0000_0000);
        wait_idle();
        rd(2'd1, 32'h0000_0004, "R7", "cmd kept");
        rd(2'd2, 32'h5555_AAAA, "R7", "payload kept");
        rd(2'd0, 32'h0000_0001, "R7", "counts kept");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule